// File: doc/BRIEF.md
# Dual-Convention Multiplexed Host Bus Front End

This block connects an 8-bit multiplexed address/data host bus to on-chip storage made of two 128-byte banks: a standard bank, whose lowest locations are clock and control registers, and an extended bank. A static mode input selects the strobe convention. In the first convention a data strobe qualifies a read/write level. In the second, separate active-low read and write strobes are used. All bus inputs are brought into the system clock domain through a synchronizer, and every strobe edge is detected there.

An address strobe falling edge captures the address into one of two independent address latches. The bank-select input, sampled at that moment, chooses which latch. During the data phase, the bank-select level chooses again which latch, and therefore which bank, is accessed. Each latch is copied into an index shadow register. The two shadows are readable at the top two extended-bank locations and are served inside the block. On the storage side the block issues single-cycle read and write pulses with address, bank and write data. It expects read data one cycle after a read pulse.

Top module: `mbus_host_if`

## Requirements
- R1: While `rst` is high, no `acc_rd`, `acc_wr` or `ad_oe` is produced, `ad_out` is 0, and both address latches and both index shadows return to 0.
- R2: A falling edge of `as_in` captures `ad_in[6:0]` into an address latch whether `cs_n` is high or low.
- R3: `bank_hi` low at the `as_in` falling edge loads the standard latch, high loads the extended latch; the other latch keeps its value.
- R4: At the data strobe event, the `bank_hi` level selects the latch used as `acc_addr` and is reported on `acc_bank` (0 standard, 1 extended).
- R5: With `moto_mode`=1, `rw_in` high and `cs_n` low, a rising `ds_in` gives one `acc_rd` pulse, and `ad_oe` is high while `ds_in` stays high.
- R6: With `moto_mode`=1, `rw_in` low and `cs_n` low, a falling `ds_in` gives one `acc_wr` pulse, with `acc_wdata` equal to `ad_in` at that edge.
- R7: With `moto_mode`=0 and `cs_n` low, a falling `ds_in` gives one `acc_rd` pulse, and `ad_oe` is high while `ds_in` stays low.
- R8: With `moto_mode`=0 and `cs_n` low, a rising `rw_in` gives one `acc_wr` pulse, with `acc_wdata` equal to `ad_in` at that edge.
- R9: A strobe edge is acted on only when `cs_n` is low in the sample of the edge and in the sample before it. `ad_oe` is never high while `cs_n` is high.
- R10: Extended-bank location 126 reads the standard index shadow and location 127 reads the extended index shadow. Neither location produces `acc_rd` or `acc_wr`, so writes to them are dropped.
- R11: `acc_ctrl` is 1 with an access exactly when the bank is standard and `acc_addr` is below 14.
- R12: Read data reaches `ad_out` two cycles after the read event. It is taken from `acc_rdata` one cycle after `acc_rd`, or from the shadow for R10 locations. Each input is acted on `SYNC_STAGES`+1 cycles after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| moto_mode | input | 1 | Static strobe convention: 1 level+strobe, 0 separate read/write strobes |
| ad_in | input | 8 | Multiplexed address/data from the bus |
| ad_out | output | 8 | Read data toward the bus |
| ad_oe | output | 1 | Bus output enable |
| as_in | input | 1 | Address strobe, address captured on its falling edge |
| ds_in | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw_in | input | 1 | Read/write level (mode 1) or active-low write strobe (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| bank_hi | input | 1 | Bank select: 0 standard, 1 extended |
| acc_rd | output | 1 | Single-cycle storage read pulse |
| acc_wr | output | 1 | Single-cycle storage write pulse |
| acc_bank | output | 1 | Bank of the current access |
| acc_addr | output | 7 | Location of the current access |
| acc_ctrl | output | 1 | Access targets a clock/control register |
| acc_wdata | output | 8 | Write data for the storage |
| acc_rdata | input | 8 | Storage read data, valid one cycle after `acc_rd` |

## Verification
The assertions watch, on every cycle, the properties that hold regardless of stimulus. These are that reset silences all strobes and the output enable, that read and write pulses are exclusive and one cycle long, and that no storage access reaches the shadow locations. They also check that a control-register flag always pairs with a low standard-bank address. Only the bench's scenarios show the rest. That covers latch selection at address time against selection at data time, and the timing of each strobe convention. It also covers chip-select gating, shadow readback of earlier addresses, dropped shadow writes and the read data latency, all compared cycle by cycle with a behavioural model.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;
  localparam int BANKS  = 2;

  // one synchronized sample of the host bus
  typedef struct packed {
    logic              as_s;
    logic              ds_s;
    logic              rw_s;
    logic              cs_n_s;
    logic              bank_s;
    logic [DATA_W-1:0] ad_s;
  } bus_smp_t;

  localparam bus_smp_t BUS_IDLE = '{as_s: 1'b0, ds_s: 1'b0, rw_s: 1'b1,
                                    cs_n_s: 1'b1, bank_s: 1'b0, ad_s: '0};
endpackage

// File: rtl/mbus_sync.sv
`timescale 1ns/1ps
module mbus_sync
  import mbus_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  bus_smp_t raw,
  output bus_smp_t cur,
  output bus_smp_t prev
);
  localparam int SW = $bits(bus_smp_t);

  logic [STAGES-1:0][SW-1:0] stg;
  logic [SW-1:0]             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg    <= {STAGES{BUS_IDLE}};
      prev_q <= BUS_IDLE;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign cur  = bus_smp_t'(stg[STAGES-1]);
  assign prev = bus_smp_t'(prev_q);
endmodule

// File: rtl/mbus_decode.sv
`timescale 1ns/1ps
module mbus_decode
  import mbus_pkg::*;
(
  input  logic     moto_mode,
  input  bus_smp_t cur,
  input  bus_smp_t prev,
  output logic     as_fall,
  output logic     rd_evt,
  output logic     wr_evt,
  output logic     rd_phase
);
  logic sel_hold;
  logic ds_rise, ds_fall, rw_rise;

  always_comb begin
    sel_hold = !cur.cs_n_s && !prev.cs_n_s;
    as_fall  = prev.as_s && !cur.as_s;
    ds_rise  = !prev.ds_s && cur.ds_s;
    ds_fall  = prev.ds_s && !cur.ds_s;
    rw_rise  = !prev.rw_s && cur.rw_s;
    if (moto_mode) begin
      rd_evt   = sel_hold && cur.rw_s && ds_rise;
      wr_evt   = sel_hold && !cur.rw_s && ds_fall;
      rd_phase = !cur.cs_n_s && cur.rw_s && cur.ds_s;
    end else begin
      rd_evt   = sel_hold && ds_fall;
      wr_evt   = sel_hold && rw_rise;
      rd_phase = !cur.cs_n_s && !cur.ds_s;
    end
  end
endmodule

// File: rtl/mbus_index.sv
`timescale 1ns/1ps
module mbus_index
  import mbus_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        as_fall,
  input  logic                        bank_sel,
  input  logic [ADDR_W-1:0]           addr_in,
  output logic [BANKS-1:0][ADDR_W-1:0] latch_o,
  output logic [BANKS-1:0][ADDR_W-1:0] shadow_o
);
  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        latch_o[g]  <= '0;
        shadow_o[g] <= '0;
      end else begin
        if (as_fall && (bank_sel == g[0])) latch_o[g] <= addr_in;
        shadow_o[g] <= latch_o[g];
      end
    end
  end
endmodule

// File: rtl/mbus_host_if.sv
`timescale 1ns/1ps
module mbus_host_if
  import mbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_CTRL    = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              moto_mode,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic              as_in,
  input  logic              ds_in,
  input  logic              rw_in,
  input  logic              cs_n,
  input  logic              bank_hi,
  output logic              acc_rd,
  output logic              acc_wr,
  output logic              acc_bank,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_ctrl,
  output logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] acc_rdata
);
  localparam logic [ADDR_W-1:0] IDX_BASE = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] CTRL_LIM = ADDR_W'(NUM_CTRL);

  bus_smp_t raw, cur, prev;
  logic     as_fall, rd_evt, wr_evt, rd_phase;
  logic [BANKS-1:0][ADDR_W-1:0] latch_v, shadow_v;
  logic [ADDR_W-1:0] sel_addr;
  logic              idx_hit;
  logic [DATA_W-1:0] idx_val;

  // read return pipeline
  logic              rd_go_q, rd_go_d;
  logic              hit_q, hit_d;
  logic [DATA_W-1:0] hval_q, hval_d;

  assign raw = '{as_s: as_in, ds_s: ds_in, rw_s: rw_in,
                 cs_n_s: cs_n, bank_s: bank_hi, ad_s: ad_in};

  mbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .raw (raw), .cur (cur), .prev (prev)
  );

  mbus_decode u_dec (
    .moto_mode (moto_mode), .cur (cur), .prev (prev),
    .as_fall (as_fall), .rd_evt (rd_evt), .wr_evt (wr_evt), .rd_phase (rd_phase)
  );

  mbus_index u_idx (
    .clk (clk), .rst (rst), .as_fall (as_fall), .bank_sel (cur.bank_s),
    .addr_in (cur.ad_s[ADDR_W-1:0]), .latch_o (latch_v), .shadow_o (shadow_v)
  );

  always_comb begin
    sel_addr = latch_v[cur.bank_s];
    idx_hit  = cur.bank_s && (sel_addr >= IDX_BASE);
    idx_val  = DATA_W'(shadow_v[sel_addr[0]]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rd    <= 1'b0;
      acc_wr    <= 1'b0;
      ad_oe     <= 1'b0;
      acc_addr  <= '0;
      acc_bank  <= 1'b0;
      acc_ctrl  <= 1'b0;
      acc_wdata <= '0;
      rd_go_q   <= 1'b0;
      rd_go_d   <= 1'b0;
      hit_q     <= 1'b0;
      hit_d     <= 1'b0;
      hval_q    <= '0;
      hval_d    <= '0;
      ad_out    <= '0;
    end else begin
      acc_rd <= rd_evt && !idx_hit;
      acc_wr <= wr_evt && !idx_hit;
      ad_oe  <= rd_phase;
      if (rd_evt || wr_evt) begin
        acc_addr <= sel_addr;
        acc_bank <= cur.bank_s;
        acc_ctrl <= !cur.bank_s && (sel_addr < CTRL_LIM);
      end
      if (wr_evt) acc_wdata <= cur.ad_s;
      rd_go_q <= rd_evt;
      hit_q   <= idx_hit;
      hval_q  <= idx_val;
      rd_go_d <= rd_go_q;
      hit_d   <= hit_q;
      hval_d  <= hval_q;
      if (rd_go_d) ad_out <= hit_d ? hval_d : acc_rdata;
    end
  end
endmodule

// File: rtl/mbus_host_if_chk.sv
`timescale 1ns/1ps
module mbus_host_if_chk
  import mbus_pkg::*;
#(
  parameter int NUM_CTRL = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic              acc_bank,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_ctrl,
  input logic              ad_oe
);
  localparam logic [ADDR_W-1:0] IDX_BASE = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] CTRL_LIM = ADDR_W'(NUM_CTRL);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!acc_rd && !acc_wr && !ad_oe));

  assert_rd_wr_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(acc_rd && acc_wr));

  assert_rd_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> !acc_rd);

  assert_wr_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    acc_wr |=> !acc_wr);

  assert_no_shadow_access_R10: assert property (@(posedge clk) disable iff (rst)
    ((acc_rd || acc_wr) && acc_bank) |-> (acc_addr < IDX_BASE));

  assert_ctrl_window_R11: assert property (@(posedge clk) disable iff (rst)
    ((acc_rd || acc_wr) && acc_ctrl) |-> (!acc_bank && (acc_addr < CTRL_LIM)));
endmodule

bind mbus_host_if mbus_host_if_chk #(.NUM_CTRL(NUM_CTRL)) u_chk (
  .clk (clk), .rst (rst), .acc_rd (acc_rd), .acc_wr (acc_wr),
  .acc_bank (acc_bank), .acc_addr (acc_addr), .acc_ctrl (acc_ctrl), .ad_oe (ad_oe)
);

// File: tb/mbus_host_if_tb.sv
`timescale 1ns/1ps
module mbus_host_if_tb;
  localparam int S = 2;
  localparam int G = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic moto_mode = 1'b1;
  logic [7:0] ad_in = '0;
  logic as_in = 1'b0, ds_in = 1'b0, rw_in = 1'b1, cs_n = 1'b1, bank_hi = 1'b0;
  logic [7:0] ad_out, acc_wdata, acc_rdata;
  logic [6:0] acc_addr;
  logic ad_oe, acc_rd, acc_wr, acc_bank, acc_ctrl;

  int vectors = 0;
  int misses  = 0;
  int wr_seen = 0;
  int rd_seen = 0;
  bit last_ctrl = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbus_host_if #(.SYNC_STAGES(S), .NUM_CTRL(14)) u_dut (
    .clk (clk), .rst (rst), .moto_mode (moto_mode), .ad_in (ad_in), .ad_out (ad_out),
    .ad_oe (ad_oe), .as_in (as_in), .ds_in (ds_in), .rw_in (rw_in), .cs_n (cs_n),
    .bank_hi (bank_hi), .acc_rd (acc_rd), .acc_wr (acc_wr), .acc_bank (acc_bank),
    .acc_addr (acc_addr), .acc_ctrl (acc_ctrl), .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata)
  );

  // storage environment driven by the DUT
  logic [7:0] env_mem [2][128];
  always @(posedge clk) begin
    if (acc_wr) env_mem[acc_bank][acc_addr] <= acc_wdata;
    if (acc_rd) acc_rdata <= env_mem[acc_bank][acc_addr];
  end

  // behavioural reference model
  typedef struct { bit a; bit d; bit w; bit c; bit b; bit [7:0] v; } smp_t;
  smp_t hist[$];
  bit [7:0] m_mem [2][128];
  bit [6:0] m_latch [2];
  bit [6:0] m_shadow [2];
  bit e_rd, e_wr, e_oe, e_bank, e_ctrl;
  bit [6:0] e_addr;
  bit [7:0] e_wdata, e_ad;
  bit pv0, pv1;
  bit [7:0] pval0, pval1;

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 128; i++) begin
        env_mem[b][i] = 8'(i ^ 8'h5A ^ (b * 8'h33));
        m_mem[b][i]   = 8'(i ^ 8'h5A ^ (b * 8'h33));
      end
    acc_rdata = '0;
  end

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      for (int i = 0; i <= S; i++) hist.push_back('{a:0, d:0, w:1, c:1, b:0, v:0});
      m_latch = '{0, 0}; m_shadow = '{0, 0};
      e_rd = 0; e_wr = 0; e_oe = 0; e_bank = 0; e_ctrl = 0; e_addr = 0;
      e_wdata = 0; e_ad = 0; pv0 = 0; pv1 = 0; pval0 = 0; pval1 = 0;
    end else begin
      smp_t p, c;
      bit sel, rd, wr, hit;
      int a;
      p = hist[0]; c = hist[1];
      sel = !c.c && !p.c;
      if (moto_mode) begin
        rd = sel && c.w && !p.d && c.d;
        wr = sel && !c.w && p.d && !c.d;
        e_oe = !c.c && c.w && c.d;
      end else begin
        rd = sel && p.d && !c.d;
        wr = sel && !p.w && c.w;
        e_oe = !c.c && !c.d;
      end
      a = c.b ? m_latch[1] : m_latch[0];
      hit = c.b && (a >= 126);
      if (pv1) e_ad = pval1;
      pv1 = pv0; pval1 = pval0;
      pv0 = rd;
      pval0 = hit ? {1'b0, m_shadow[a % 2]} : m_mem[c.b][a];
      e_rd = rd && !hit;
      e_wr = wr && !hit;
      if (rd || wr) begin
        e_addr = 7'(a); e_bank = c.b; e_ctrl = !c.b && (a < 14);
      end
      if (wr) e_wdata = c.v;
      if (wr && !hit) m_mem[c.b][a] = c.v;
      m_shadow = m_latch;
      if (p.a && !c.a) m_latch[c.b] = c.v[6:0];
      void'(hist.pop_front());
      hist.push_back('{a:as_in, d:ds_in, w:rw_in, c:cs_n, b:bank_hi, v:ad_in});
    end
  end

  task automatic miss(string tag, string what, int act, int exp);
    misses++;
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    string trd, twr;
    trd = rst ? "R1" : (moto_mode ? "R5" : "R7");
    twr = rst ? "R1" : (moto_mode ? "R6" : "R8");
    vectors++;
    if (acc_rd !== e_rd) miss(trd, "acc_rd", int'(acc_rd), int'(e_rd));
    if (acc_wr !== e_wr) miss(twr, "acc_wr", int'(acc_wr), int'(e_wr));
    if (ad_oe !== e_oe) miss(cs_n ? "R9" : trd, "ad_oe", int'(ad_oe), int'(e_oe));
    if (ad_out !== e_ad) miss(rst ? "R1" : "R12", "ad_out", int'(ad_out), int'(e_ad));
    if (e_rd || e_wr) begin
      if (acc_addr !== e_addr) miss("R4", "acc_addr", int'(acc_addr), int'(e_addr));
      if (acc_bank !== e_bank) miss("R4", "acc_bank", int'(acc_bank), int'(e_bank));
      if (acc_ctrl !== e_ctrl) miss("R11", "acc_ctrl", int'(acc_ctrl), int'(e_ctrl));
    end
    if (e_wr && acc_wdata !== e_wdata) miss(twr, "acc_wdata", int'(acc_wdata), int'(e_wdata));
    if (acc_wr === 1'b1) begin wr_seen++; last_ctrl = acc_ctrl; end
    if (acc_rd === 1'b1) rd_seen++;
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    vectors++;
    if (!ok) miss(tag, what, act, exp);
  endtask

  task automatic gap(int n); repeat (n) @(negedge clk); endtask

  task automatic latch_addr(bit bank, bit [7:0] addr);
    @(negedge clk); bank_hi = bank; ad_in = addr; as_in = 1'b1;
    gap(G); as_in = 1'b0;
    gap(G);
  endtask

  task automatic m_write(bit bank, bit [7:0] data);
    @(negedge clk); bank_hi = bank; cs_n = 1'b0; rw_in = 1'b0;
    gap(G); ad_in = data; ds_in = 1'b1;
    gap(G); ds_in = 1'b0;
    gap(G); cs_n = 1'b1; rw_in = 1'b1;
    gap(G);
  endtask

  task automatic m_read(bit bank, output bit [7:0] data, output bit oe);
    @(negedge clk); bank_hi = bank; cs_n = 1'b0; rw_in = 1'b1;
    gap(G); ds_in = 1'b1;
    gap(G); data = ad_out; oe = ad_oe;
    ds_in = 1'b0;
    gap(G); cs_n = 1'b1;
    gap(G);
  endtask

  task automatic i_write(bit bank, bit [7:0] data);
    @(negedge clk); bank_hi = bank; cs_n = 1'b0; ad_in = data; rw_in = 1'b0;
    gap(G); rw_in = 1'b1;
    gap(G); cs_n = 1'b1;
    gap(G);
  endtask

  task automatic i_read(bit bank, output bit [7:0] data, output bit oe);
    @(negedge clk); bank_hi = bank; cs_n = 1'b0;
    gap(G); ds_in = 1'b0;
    gap(G); data = ad_out; oe = ad_oe;
    ds_in = 1'b1;
    gap(G); cs_n = 1'b1;
    gap(G);
  endtask

  initial begin
    bit [7:0] d;
    bit oe;
    int w0, r0;
    gap(4);
    check(ad_oe === 1'b0, "R1", "ad_oe in reset", int'(ad_oe), 0);
    check(ad_out === 8'h00, "R1", "ad_out in reset", int'(ad_out), 0);
    @(negedge clk) rst = 1'b0;
    gap(4);

    // first convention: addresses latched with chip select high
    latch_addr(1'b0, 8'h05);
    latch_addr(1'b1, 8'h20);
    m_write(1'b0, 8'hC3);
    m_read(1'b0, d, oe);
    check(d == 8'hC3, "R6", "std readback", int'(d), 'hC3);
    check(oe == 1'b1, "R5", "oe during read", int'(oe), 1);
    check(ad_oe === 1'b0, "R5", "oe after read", int'(ad_oe), 0);
    m_write(1'b1, 8'h96);
    m_read(1'b1, d, oe);
    check(d == 8'h96, "R4", "ext readback", int'(d), 'h96);
    m_read(1'b0, d, oe);
    check(d == 8'hC3, "R3", "std latch kept", int'(d), 'hC3);
    m_read(1'b1, d, oe);
    check(d == 8'h96, "R2", "ext latch kept", int'(d), 'h96);

    // index shadows
    latch_addr(1'b1, 8'h7E);
    m_read(1'b1, d, oe);
    check(d == 8'h05, "R10", "std index via 126", int'(d), 'h05);
    latch_addr(1'b1, 8'h7F);
    m_read(1'b1, d, oe);
    check(d == 8'h7F, "R10", "ext index via 127", int'(d), 'h7F);
    w0 = wr_seen;
    m_write(1'b1, 8'h11);
    check(wr_seen == w0, "R10", "write to 127 issued", wr_seen, w0);
    m_read(1'b1, d, oe);
    check(d == 8'h7F, "R10", "127 after write", int'(d), 'h7F);

    // control-register window boundary
    latch_addr(1'b0, 8'h0D);
    m_write(1'b0, 8'h42);
    check(last_ctrl == 1'b1, "R11", "ctrl at 13", int'(last_ctrl), 1);
    latch_addr(1'b0, 8'h0E);
    m_write(1'b0, 8'h43);
    check(last_ctrl == 1'b0, "R11", "ctrl at 14", int'(last_ctrl), 0);

    // strobes with chip select high
    r0 = rd_seen; w0 = wr_seen;
    @(negedge clk) bank_hi = 1'b0; rw_in = 1'b1;
    gap(G); ds_in = 1'b1;
    gap(G);
    check(ad_oe === 1'b0, "R9", "oe with cs high", int'(ad_oe), 0);
    ds_in = 1'b0;
    gap(G); rw_in = 1'b0; ds_in = 1'b1;
    gap(G); ds_in = 1'b0;
    gap(G); rw_in = 1'b1;
    gap(G);
    check(rd_seen == r0, "R9", "reads with cs high", rd_seen, r0);
    check(wr_seen == w0, "R9", "writes with cs high", wr_seen, w0);

    // accesses during reset
    @(negedge clk) rst = 1'b1;
    w0 = wr_seen;
    latch_addr(1'b0, 8'h33);
    m_write(1'b0, 8'h77);
    check(wr_seen == w0, "R1", "write in reset", wr_seen, w0);
    @(negedge clk) rst = 1'b0;
    gap(4);
    latch_addr(1'b1, 8'h7E);
    m_read(1'b1, d, oe);
    check(d == 8'h00, "R1", "std index cleared", int'(d), 0);

    // second convention
    @(negedge clk) rst = 1'b1; moto_mode = 1'b0; ds_in = 1'b1; rw_in = 1'b1;
    gap(4);
    @(negedge clk) rst = 1'b0;
    gap(4);
    latch_addr(1'b0, 8'h30);
    i_write(1'b0, 8'h5A);
    check(last_ctrl == 1'b0, "R8", "ctrl flag at 0x30", int'(last_ctrl), 0);
    i_read(1'b0, d, oe);
    check(d == 8'h5A, "R8", "intel readback", int'(d), 'h5A);
    check(oe == 1'b1, "R7", "oe while read strobe low", int'(oe), 1);
    latch_addr(1'b1, 8'h7E);
    i_read(1'b1, d, oe);
    check(d == 8'h30, "R10", "intel std index", int'(d), 'h30);
    w0 = wr_seen;
    @(negedge clk) bank_hi = 1'b0; rw_in = 1'b0;
    gap(G); rw_in = 1'b1;
    gap(G);
    check(wr_seen == w0, "R9", "intel write cs high", wr_seen, w0);
    latch_addr(1'b0, 8'h02);
    i_write(1'b0, 8'hE1);
    check(last_ctrl == 1'b1, "R11", "intel ctrl at 2", int'(last_ctrl), 1);
    i_read(1'b0, d, oe);
    check(d == 8'hE1, "R7", "intel ctrl readback", int'(d), 'hE1);

    gap(G);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule